// File: doc/BRIEF.md
# ALU with Condition-Code Flags

This unit is the arithmetic and logic stage of a small load/store processor. It takes a 5-bit operation code and two 32-bit operands and returns a 32-bit result in the same cycle. It offers seven operations: add, subtract, bit-wise OR, AND, XOR, one-operand complement, and compare. It also raises a write request whenever the result should go back to the register file. The caller prepares the operands, including any sign-extended immediate. Writeback and instruction sequencing also happen outside the block.

Four condition flags sit in a register: carry (C), overflow (V), negative (N) and zero (Z). They load on a rising clock edge when the update strobe is high and the code names a real operation. Compare runs through the subtract path and loads all four flags, but it gives no result and no write request. Branch logic elsewhere reads the flags.

Top module: `alu_cc`

## Requirements
- R1: Code 1 (add) drives `result` = opA + opB modulo 2^32 and raises `writeReq`.
- R2: Code 2 (subtract) drives `result` = opA - opB modulo 2^32 and raises `writeReq`.
- R3: Codes 3 (OR), 4 (AND) and 6 (XOR) drive the bit-wise combination of opA and opB. Code 5 drives the complement of opA and ignores opB. All four codes raise `writeReq`.
- R4: Code 7 (compare) drives `result` to zero and keeps `writeReq` low. On a flag load it sets C, V, N and Z exactly as a subtract of the same operands would.
- R5: Code 0 and codes 8 to 31 drive `result` to zero, keep `writeReq` low and never change the flags, even when `updEn` is high.
- R6: On a flag load after an add, C is the carry out of bit 31. After a subtract or a compare, C is the carry out of opA + ~opB + 1, so C=1 means no borrow occurred.
- R7: On a flag load after an add, subtract or compare, V is 1 exactly when the true signed result lies outside -2^31 to 2^31-1.
- R8: On a flag load, N takes bit 31 of the computed value and Z is 1 exactly when all 32 bits of it are 0. For compare, the computed value is the difference.
- R9: On a flag load after codes 3 to 6, C and V are both cleared.
- R10: The flags change only on a rising clock edge where `updEn` is 1 and the code is 1 to 7. At every other edge they hold.
- R11: An active-low asynchronous reset clears all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| opCode | input | 5 | Operation code |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| updEn | input | 1 | Flag-update strobe |
| result | output | 32 | Combinational result |
| writeReq | output | 1 | Result should be written back |
| flagC | output | 1 | Registered carry flag |
| flagV | output | 1 | Registered overflow flag |
| flagN | output | 1 | Registered negative flag |
| flagZ | output | 1 | Registered zero flag |

## Verification
The combinational result of the current operation appears in the same cycle as the flags left by an earlier operation. One operation's flag load and the next operation's evaluation therefore overlap. The bench provokes this in several ways: a compare is followed by an add with the strobe low, and flag-setting arithmetic is followed by logic operations and by inactive codes with the strobe high. In each cycle the bench checks the fresh result and write request against its model. It checks the flags against the model's stored copy both before and after the edge, which shows whether the load happened or the flags held.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

  localparam int unsigned OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_NOP = 5'd0,
    OP_ADD = 5'd1,
    OP_SUB = 5'd2,
    OP_OR  = 5'd3,
    OP_AND = 5'd4,
    OP_NOT = 5'd5,
    OP_XOR = 5'd6,
    OP_CMP = 5'd7
  } aluOp_e;

  typedef enum logic [2:0] {
    SEL_ZERO,
    SEL_SUM,
    SEL_OR,
    SEL_AND,
    SEL_NOT,
    SEL_XOR
  } resSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    invertB;   // feed ~B into the adder
    logic    carryIn;   // +1 for two's-complement subtract
    logic    arith;     // C and V come from the adder
    logic    showOut;   // put computed value on the result port
    logic    writeReq;  // request register writeback
    logic    flagLoad;  // load condition flags this edge
    resSel_e sel;       // which unit forms the value
  } aluCtrl_t;

  typedef struct packed {
    logic c;
    logic v;
    logic n;
    logic z;
  } ccFlags_t;

endpackage

// File: rtl/alu_cc_ctrl.sv
module alu_cc_ctrl
  import alu_cc_pkg::*;
(
  input  logic [OP_W-1:0] opCode,
  input  logic            updEn,
  output aluCtrl_t        ctrl
);

  logic validOp;

  always_comb begin
    ctrl          = '0;
    ctrl.sel      = SEL_ZERO;
    validOp       = 1'b1;
    case (opCode)
      OP_ADD: begin
        ctrl.sel      = SEL_SUM;
        ctrl.arith    = 1'b1;
        ctrl.showOut  = 1'b1;
        ctrl.writeReq = 1'b1;
      end
      OP_SUB: begin
        ctrl.sel      = SEL_SUM;
        ctrl.invertB  = 1'b1;
        ctrl.carryIn  = 1'b1;
        ctrl.arith    = 1'b1;
        ctrl.showOut  = 1'b1;
        ctrl.writeReq = 1'b1;
      end
      OP_CMP: begin
        // same path as subtract, value kept internal
        ctrl.sel      = SEL_SUM;
        ctrl.invertB  = 1'b1;
        ctrl.carryIn  = 1'b1;
        ctrl.arith    = 1'b1;
      end
      OP_OR: begin
        ctrl.sel      = SEL_OR;
        ctrl.showOut  = 1'b1;
        ctrl.writeReq = 1'b1;
      end
      OP_AND: begin
        ctrl.sel      = SEL_AND;
        ctrl.showOut  = 1'b1;
        ctrl.writeReq = 1'b1;
      end
      OP_NOT: begin
        ctrl.sel      = SEL_NOT;
        ctrl.showOut  = 1'b1;
        ctrl.writeReq = 1'b1;
      end
      OP_XOR: begin
        ctrl.sel      = SEL_XOR;
        ctrl.showOut  = 1'b1;
        ctrl.writeReq = 1'b1;
      end
      default: validOp = 1'b0;
    endcase
    ctrl.flagLoad = updEn & validOp;
  end

endmodule

// File: rtl/alu_cc_flagreg.sv
module alu_cc_flagreg
  import alu_cc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  ccFlags_t nextFlags,
  output ccFlags_t flags
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flags <= '0;
    else if (load)
      flags <= nextFlags;
  end

endmodule

// File: rtl/alu_cc_dp.sv
module alu_cc_dp
  import alu_cc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  aluCtrl_t          ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output ccFlags_t          flags
);

  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] bOperand;
  logic [DATA_W:0]   sumWide;
  logic [DATA_W-1:0] rawValue;
  logic              signOvf;
  ccFlags_t          nextFlags;

  assign bOperand = ctrl.invertB ? ~opB : opB;
  assign sumWide  = {1'b0, opA} + {1'b0, bOperand} + {{DATA_W{1'b0}}, ctrl.carryIn};

  // overflow: same-sign adder inputs giving an opposite-sign sum
  assign signOvf  = (opA[MSB] == bOperand[MSB]) && (sumWide[MSB] != opA[MSB]);

  always_comb begin
    case (ctrl.sel)
      SEL_SUM: rawValue = sumWide[DATA_W-1:0];
      SEL_OR:  rawValue = opA | opB;
      SEL_AND: rawValue = opA & opB;
      SEL_NOT: rawValue = ~opA;
      SEL_XOR: rawValue = opA ^ opB;
      default: rawValue = '0;
    endcase
  end

  always_comb begin
    nextFlags.c = ctrl.arith & sumWide[DATA_W];
    nextFlags.v = ctrl.arith & signOvf;
    nextFlags.n = rawValue[MSB];
    nextFlags.z = ~|rawValue;
  end

  assign result = ctrl.showOut ? rawValue : '0;

  alu_cc_flagreg u_flagreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ctrl.flagLoad),
    .nextFlags (nextFlags),
    .flags     (flags)
  );

endmodule

// File: rtl/alu_cc.sv
module alu_cc
  import alu_cc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              updEn,
  output logic [DATA_W-1:0] result,
  output logic              writeReq,
  output logic              flagC,
  output logic              flagV,
  output logic              flagN,
  output logic              flagZ
);

  aluCtrl_t ctrl;
  ccFlags_t flags;

  alu_cc_ctrl u_ctrl (
    .opCode (opCode),
    .updEn  (updEn),
    .ctrl   (ctrl)
  );

  alu_cc_dp #(.DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctrl   (ctrl),
    .opA    (opA),
    .opB    (opB),
    .result (result),
    .flags  (flags)
  );

  assign writeReq = ctrl.writeReq;
  assign flagC    = flags.c;
  assign flagV    = flags.v;
  assign flagN    = flags.n;
  assign flagZ    = flags.z;

endmodule

// File: rtl/alu_cc_checker.sv
module alu_cc_checker #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [4:0]        opCode,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic              updEn,
  input logic [DATA_W-1:0] result,
  input logic              writeReq,
  input logic              flagC,
  input logic              flagV,
  input logic              flagN,
  input logic              flagZ
);

  logic [DATA_W:0] addRef;
  logic            realOp;
  logic            logicOp;

  assign addRef  = {1'b0, opA} + {1'b0, opB};
  assign realOp  = (opCode >= 5'd1) && (opCode <= 5'd7);
  assign logicOp = (opCode >= 5'd3) && (opCode <= 5'd6);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(updEn && realOp) |=> $stable({flagC, flagV, flagN, flagZ}));

  assert_cmp_nowrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode == 5'd7) |-> (!writeReq && result == '0));

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !realOp |-> (!writeReq && result == '0));

  assert_logic_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (updEn && logicOp) |=> (!flagC && !flagV));

  assert_add_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (updEn && opCode == 5'd1) |=> (flagC == $past(addRef[DATA_W])));

  assert_nz_track_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (updEn && realOp && opCode != 5'd7) |=>
      (flagN == $past(result[DATA_W-1]) && flagZ == ($past(result) == '0)));

  assert_add_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode == 5'd1) |-> (writeReq && result == addRef[DATA_W-1:0]));

endmodule

bind alu_cc alu_cc_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .opCode   (opCode),
  .opA      (opA),
  .opB      (opB),
  .updEn    (updEn),
  .result   (result),
  .writeReq (writeReq),
  .flagC    (flagC),
  .flagV    (flagV),
  .flagN    (flagN),
  .flagZ    (flagZ)
);

// File: tb/alu_cc_test.sv
`timescale 1ns/1ps
module alu_cc_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  opCode = '0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        updEn = 1'b0;
  logic [31:0] result;
  logic        writeReq;
  logic        flagC, flagV, flagN, flagZ;

  int   testCount = 0;
  int   failCount = 0;
  bit   finished  = 1'b0;
  logic [3:0] modelFlags = 4'b0;   // {C,V,N,Z}

  always #5 clk = ~clk;

  alu_cc uut (
    .clk(clk), .rst_n(rst_n), .opCode(opCode), .opA(opA), .opB(opB),
    .updEn(updEn), .result(result), .writeReq(writeReq),
    .flagC(flagC), .flagV(flagV), .flagN(flagN), .flagZ(flagZ)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    testCount++;
    if (got !== exp) begin
      failCount++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // behavioural reference for one operation
  function automatic void refOp(input int op, input logic [31:0] a, input logic [31:0] b,
                                output logic [31:0] res, output logic wr,
                                output logic upd, output logic [3:0] nf);
    longint ua = longint'(a);
    longint ub = longint'(b);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint full = 0;
    longint exact = 0;
    logic [31:0] val = '0;
    logic c = 1'b0, v = 1'b0;
    upd = (op >= 1) && (op <= 7);
    wr  = (op >= 1) && (op <= 6);
    case (op)
      1: begin full = ua + ub; exact = sa + sb; end
      2, 7: begin full = ua + ((~ub) & 64'hFFFF_FFFF) + 1; exact = sa - sb; end
      3: val = a | b;
      4: val = a & b;
      5: val = ~a;
      6: val = a ^ b;
      default: val = '0;
    endcase
    if (op == 1 || op == 2 || op == 7) begin
      val = full[31:0];
      c   = full[32];
      v   = (exact > 64'sd2147483647) || (exact < -64'sd2147483648);
    end
    nf  = {c, v, val[31], (val == 32'd0)};
    res = (wr) ? val : 32'd0;
  endfunction

  task automatic runOp(input string tag, input int op, input logic [31:0] a,
                       input logic [31:0] b, input logic en);
    logic [31:0] expRes;
    logic expWr, upd;
    logic [3:0] nf;
    @(negedge clk);
    opCode = op[4:0]; opA = a; opB = b; updEn = en;
    #1;
    refOp(op, a, b, expRes, expWr, upd, nf);
    check(tag, "result", result, expRes);
    check(tag, "writeReq", {31'd0, writeReq}, {31'd0, expWr});
    check(tag, "flags before edge", {28'd0, flagC, flagV, flagN, flagZ}, {28'd0, modelFlags});
    @(posedge clk);
    #1;
    if (en && upd) modelFlags = nf;
    check(tag, "flags after edge", {28'd0, flagC, flagV, flagN, flagZ}, {28'd0, modelFlags});
  endtask

  initial begin
    #1;
    check("R11", "flags in reset", {28'd0, flagC, flagV, flagN, flagZ}, 32'd0);
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 / R6 / R8: unsigned wrap gives carry and zero
    runOp("R1_R6_R8", 1, 32'hFFFF_FFFF, 32'h0000_0001, 1'b1);
    // R1 / R7: signed overflow into negative
    runOp("R1_R7", 1, 32'h7FFF_FFFF, 32'h0000_0001, 1'b1);
    // R2 / R6: no borrow gives C=1
    runOp("R2_R6", 2, 32'd5, 32'd3, 1'b1);
    // R2 / R6 / R8: borrow gives C=0, negative
    runOp("R2_R6_borrow", 2, 32'd3, 32'd5, 1'b1);
    // R7: subtract overflow
    runOp("R7_sub", 2, 32'h8000_0000, 32'd1, 1'b1);
    // R4: compare of equal values
    runOp("R4_eq", 7, 32'h1234_5678, 32'h1234_5678, 1'b1);
    // R4: compare less, then an add with no load must leave compare flags
    runOp("R4_lt", 7, 32'd1, 32'd2, 1'b1);
    runOp("R10_add_noload", 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    // R9 / R3: set C and V first, logic ops must clear them
    runOp("R7_setup", 1, 32'h8000_0000, 32'h8000_0000, 1'b1);
    runOp("R3_R9_or", 3, 32'hF0F0_0000, 32'h0F0F_0000, 1'b1);
    runOp("R7_setup2", 1, 32'h8000_0000, 32'h8000_0000, 1'b1);
    runOp("R3_R9_and", 4, 32'hF0F0_FFFF, 32'h0F0F_0000, 1'b1);
    runOp("R3_R9_not", 5, 32'h0000_FFFF, 32'hDEAD_BEEF, 1'b1);
    runOp("R3_R9_xor", 6, 32'hAAAA_5555, 32'hAAAA_5555, 1'b1);
    // R5 / R10: inactive codes with the strobe high leave flags untouched
    runOp("R7_setup3", 2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    runOp("R5_nop", 0, 32'h0000_0000, 32'h0000_0000, 1'b1);
    runOp("R5_code8", 8, 32'h1, 32'h1, 1'b1);
    runOp("R5_code31", 31, 32'hFFFF_FFFF, 32'h1, 1'b1);

    // mixed stream
    for (int i = 0; i < 300; i++) begin
      int op = int'($urandom_range(0, 10));
      logic [31:0] a = $urandom();
      logic [31:0] b = (i % 7 == 0) ? a : $urandom();
      runOp("R10_mixed", op, a, b, 1'($urandom_range(0, 1)));
    end

    // R11: asynchronous reset mid-run
    runOp("R7_setup4", 1, 32'h8000_0000, 32'h8000_0000, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    modelFlags = 4'b0;
    check("R11", "flags after async reset", {28'd0, flagC, flagV, flagN, flagZ}, 32'd0);
    @(negedge clk) rst_n = 1'b1;

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule